// File: doc/BRIEF.md
# Multiplexed Eight-Pin General-Purpose Port

This block is an eight-pin general-purpose I/O port. It holds an output data latch and a per-pin direction register, and sits behind a small register bus with an address, a write strobe, write data and combinational read data. For every pin it produces an output value and an output enable for the pad, and it brings the pad levels back through a two-stage synchronizer.

Each pin can also be claimed by an on-chip peripheral. Pins 0 and 1 belong to a two-wire serial bus and are driven open-drain. Pins 2 and 3 belong to an asynchronous serial port. Pins 4 to 7 belong to the four channels of two dual-channel timers. While a peripheral owns a pin, the port registers have no effect on that pin's pad drive.

The registers keep their contents whatever the peripherals are doing. Software can therefore preload an output value into the data latch while the pin is still an input, and only then turn the driver on. There is no streamed data here: every interface is a plain level or a register strobe, with no back-pressure.

Top module: `gpio_pmux_port`

## Requirements
- R1: After reset, the direction register and the data latch are both 0x00, so `pad_oe` is 0x00 and `pad_out` is 0x00 while no peripheral is enabled.
- R2: The direction register is at address 0x05 and can be read and written in full. Setting bit n to 1 asserts `pad_oe[n]` on a pin that no peripheral owns, and 0 releases it.
- R3: The data latch is at address 0x01. On a pin that no peripheral owns, `pad_out[n]` equals latch bit n from the clock edge that follows the write.
- R4: The data latch accepts writes while the direction bits are 0, and `pad_oe` stays 0 during such a write. When the direction bits are later set, the pad shows the preloaded value in the same cycle.
- R5: A read of address 0x01 returns, bit by bit, the latch bit when the direction bit is 1 and the synchronized pad level when it is 0.
- R6: A change on `pad_in` reaches `pin_sync` and the read-back after exactly two clock edges, and does not appear after only one.
- R7: While `twi_en` is 1, pins 0 and 1 drive 0 (`pad_out` bit = 0). Their `pad_oe` is the inverse of `twi_sda_o` for pin 0 and of `twi_scl_o` for pin 1. The port registers have no effect on these two pins.
- R8: While `uart_en` is 1, pin 2 drives `uart_txd` with `pad_oe[2]` = 1, and pin 3 has `pad_oe[3]` = 0, whatever the register contents.
- R9: Timer channel k (k = 0..3, timer 1 channels 0 and 1 then timer 2 channels 0 and 1) has a 2-bit select at `tmr_sel[2k+1:2k]` and owns pin 4+k when that select is nonzero. The owned pin takes `tmr_out[k]` and `tmr_oe[k]`. A select of 00 leaves the pin to the port registers.
- R10: A write to any address other than 0x01 and 0x05 changes neither register, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output value per pad |
| pad_oe | output | 8 | Output enable per pad |
| pin_sync | output | 8 | Synchronized pad levels for the peripherals |
| twi_en | input | 1 | Two-wire serial function enable |
| twi_sda_o | input | 1 | Two-wire data drive (0 pulls low) |
| twi_scl_o | input | 1 | Two-wire clock drive (0 pulls low) |
| uart_en | input | 1 | Asynchronous serial enable |
| uart_txd | input | 1 | Transmit data value |
| tmr_sel | input | 8 | Edge/level select, 2 bits per timer channel |
| tmr_out | input | 4 | Timer channel drive values |
| tmr_oe | input | 4 | Timer channel drive enables |

## Verification
The pad drive (`pad_out`, `pad_oe`) depends combinationally on the peripheral inputs, so those results are due in the same cycle as the stimulus. After a register write they are due right after the one clock edge that samples the strobe. `reg_rdata` follows the address combinationally. Pad levels need two edges before they reach `pin_sync` and the read-back. Each check is queued by the driver just after a rising edge and compared by the monitor at the following falling edge. For the synchronizer, the pattern is sampled after zero, one and two edges, so both the too-early value and the due value are checked.

// File: rtl/gpio_pmux_pkg.sv
package gpio_pmux_pkg;
  localparam int PORT_W = 8;
  localparam int TMR_CH = 4;
  localparam int SEL_W  = 2;
  localparam int TWI_LO = 0;
  localparam int UART_LO = 2;
  localparam int TMR_LO = 4;

  typedef enum logic [1:0] {
    GRP_TWI  = 2'd0,
    GRP_UART = 2'd1,
    GRP_TMR  = 2'd2
  } pin_grp_e;

  function automatic pin_grp_e grp_of(input int pin);
    if (pin < UART_LO) return GRP_TWI;
    else if (pin < TMR_LO) return GRP_UART;
    else return GRP_TMR;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_in;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    p_two_edge_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (d_out == $past(d_in, 2)));
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pmux_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q
);
  logic hit_data, hit_dir;
  assign hit_data = (addr == DATA_ADDR);
  assign hit_dir  = (addr == DIR_ADDR);

  // latch is writable whatever the direction bits say
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (wr_en && hit_data) data_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (wr_en && hit_dir) dir_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (hit_data) rdata = (dir_q & data_q) | (~dir_q & pin_sync);
    else if (hit_dir) rdata = dir_q;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && data_q == '0));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dir) |=> (dir_q == $past(wdata)));
  p_latch_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_data) |=> (data_q == $past(wdata)));
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_data && !hit_dir) |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pmux_pkg::*;
(
  input  logic                    data_q_bit_unused_n,
  input  logic [PORT_W-1:0]       data_q,
  input  logic [PORT_W-1:0]       dir_q,
  input  logic                    twi_en,
  input  logic                    twi_sda_o,
  input  logic                    twi_scl_o,
  input  logic                    uart_en,
  input  logic                    uart_txd,
  input  logic [TMR_CH*SEL_W-1:0] tmr_sel,
  input  logic [TMR_CH-1:0]       tmr_out,
  input  logic [TMR_CH-1:0]       tmr_oe,
  output logic [PORT_W-1:0]       pad_out,
  output logic [PORT_W-1:0]       pad_oe
);
  logic unused_tie;
  assign unused_tie = data_q_bit_unused_n;

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    localparam pin_grp_e GRP = grp_of(p);
    logic own, per_o, per_oe;

    if (GRP == GRP_TWI) begin : g_twi
      logic line_hi;
      if (p == TWI_LO) begin : g_sda
        assign line_hi = twi_sda_o;
      end else begin : g_scl
        assign line_hi = twi_scl_o;
      end
      // open drain: drive only a low level
      assign own    = twi_en;
      assign per_o  = 1'b0;
      assign per_oe = ~line_hi;
    end else if (GRP == GRP_UART) begin : g_uart
      assign own = uart_en;
      if (p == UART_LO) begin : g_tx
        assign per_o  = uart_txd;
        assign per_oe = 1'b1;
      end else begin : g_rx
        assign per_o  = 1'b0;
        assign per_oe = 1'b0;
      end
    end else begin : g_tmr
      localparam int CH = p - TMR_LO;
      assign own    = |tmr_sel[CH*SEL_W +: SEL_W];
      assign per_o  = tmr_out[CH];
      assign per_oe = tmr_oe[CH];
    end

    assign pad_out[p] = own ? per_o  : data_q[p];
    assign pad_oe[p]  = own ? per_oe : dir_q[p];
  end
endmodule

// File: rtl/gpio_pmux_port.sv
module gpio_pmux_port
  import gpio_pmux_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h05,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [PORT_W-1:0]       reg_wdata,
  output logic [PORT_W-1:0]       reg_rdata,
  input  logic [PORT_W-1:0]       pad_in,
  output logic [PORT_W-1:0]       pad_out,
  output logic [PORT_W-1:0]       pad_oe,
  output logic [PORT_W-1:0]       pin_sync,
  input  logic                    twi_en,
  input  logic                    twi_sda_o,
  input  logic                    twi_scl_o,
  input  logic                    uart_en,
  input  logic                    uart_txd,
  input  logic [TMR_CH*SEL_W-1:0] tmr_sel,
  input  logic [TMR_CH-1:0]       tmr_out,
  input  logic [TMR_CH-1:0]       tmr_oe
);
  logic [PORT_W-1:0] data_q, dir_q;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pin_sync)
  );

  gpio_regfile #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr), .wdata(reg_wdata),
    .pin_sync(pin_sync), .rdata(reg_rdata), .data_q(data_q), .dir_q(dir_q)
  );

  gpio_pin_mux u_mux (
    .data_q_bit_unused_n(1'b0),
    .data_q(data_q), .dir_q(dir_q),
    .twi_en(twi_en), .twi_sda_o(twi_sda_o), .twi_scl_o(twi_scl_o),
    .uart_en(uart_en), .uart_txd(uart_txd),
    .tmr_sel(tmr_sel), .tmr_out(tmr_out), .tmr_oe(tmr_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  p_twi_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    twi_en |-> (pad_out[1:0] == 2'b00 && pad_oe[0] == !twi_sda_o && pad_oe[1] == !twi_scl_o));
  p_uart_rx_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en |-> (!pad_oe[3] && pad_oe[2] && pad_out[2] == uart_txd));
  p_tmr_gpio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_sel[1:0] == 2'b00) |-> (pad_oe[4] == dir_q[4] && pad_out[4] == data_q[4]));
  p_gpio_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!twi_en && !uart_en && tmr_sel == '0) |-> (pad_oe == dir_q && pad_out == data_q));
endmodule

// File: tb/gpio_pmux_port_tb.sv
module gpio_pmux_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, pad_in = '0, tmr_sel = '0;
  logic reg_wr = 1'b0, twi_en = 1'b0, twi_sda_o = 1'b1, twi_scl_o = 1'b1;
  logic uart_en = 1'b0, uart_txd = 1'b1;
  logic [3:0] tmr_out = '0, tmr_oe = '0;
  logic [7:0] reg_rdata, pad_out, pad_oe, pin_sync;

  always #2.5 clk = ~clk;

  gpio_pmux_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync),
    .twi_en(twi_en), .twi_sda_o(twi_sda_o), .twi_scl_o(twi_scl_o),
    .uart_en(uart_en), .uart_txd(uart_txd),
    .tmr_sel(tmr_sel), .tmr_out(tmr_out), .tmr_oe(tmr_oe)
  );

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = reg_rdata;
        1: act = pad_out;
        2: act = pad_oe;
        default: act = pin_sync;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    push(0, exp, tag);
    step();
  endtask

  task automatic pad_chk(input logic [7:0] o, input logic [7:0] oe, input string tag);
    push(1, o, tag);
    push(2, oe, tag);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    rd_chk(8'h05, 8'h00, "R1 dir after reset");
    pad_chk(8'h00, 8'h00, "R1 pads after reset");
    // R2 direction register
    reg_write(8'h05, 8'hA5);
    rd_chk(8'h05, 8'hA5, "R2 dir readback");
    pad_chk(8'h00, 8'hA5, "R2 oe follows dir");
    // R4 preload while input, R3 drive
    reg_write(8'h05, 8'h00);
    reg_write(8'h01, 8'h3C);
    push(2, 8'h00, "R4 oe stays off during preload"); step();
    reg_write(8'h05, 8'hFF);
    pad_chk(8'h3C, 8'hFF, "R3 R4 preloaded value on enable");
    rd_chk(8'h01, 8'h3C, "R5 all-output readback");
    // R5 mixed readback
    reg_write(8'h05, 8'h0F);
    pad_in = 8'hA0;
    repeat (3) step();
    rd_chk(8'h01, 8'hAC, "R5 mixed readback");
    // R6 synchronizer timing
    reg_write(8'h05, 8'h00);
    pad_in = 8'h00;
    repeat (3) step();
    @(posedge clk); #1;
    pad_in = 8'h55;
    push(3, 8'h00, "R6 before any edge"); step();
    push(3, 8'h00, "R6 after one edge"); step();
    push(3, 8'h55, "R6 after two edges");
    reg_addr = 8'h01;
    push(0, 8'h55, "R6 readback after two edges"); step();
    // R7 two-wire open drain
    reg_write(8'h05, 8'hFF);
    reg_write(8'h01, 8'hFF);
    twi_en = 1'b1; twi_sda_o = 1'b0; twi_scl_o = 1'b1;
    pad_chk(8'hFC, 8'hFD, "R7 sda low scl released");
    reg_write(8'h05, 8'h00);
    reg_write(8'h01, 8'h00);
    pad_chk(8'h00, 8'h01, "R7 registers no effect");
    twi_sda_o = 1'b1; twi_scl_o = 1'b0;
    pad_chk(8'h00, 8'h02, "R7 scl low sda released");
    twi_en = 1'b0;
    // R8 asynchronous serial
    reg_write(8'h05, 8'hFF);
    uart_en = 1'b1; uart_txd = 1'b1;
    pad_chk(8'h04, 8'hF7, "R8 txd high rx input");
    uart_txd = 1'b0;
    pad_chk(8'h00, 8'hF7, "R8 txd low");
    uart_en = 1'b0;
    // R9 timers
    reg_write(8'h05, 8'h00);
    tmr_sel = 8'b00_00_00_01; tmr_out = 4'b1111; tmr_oe = 4'b1111;
    pad_chk(8'h10, 8'h10, "R9 channel0 only");
    tmr_sel = 8'b10_01_11_10; tmr_out = 4'b1010; tmr_oe = 4'b0110;
    pad_chk(8'hA0, 8'h60, "R9 all channels");
    tmr_sel = 8'h00;
    pad_chk(8'h00, 8'h00, "R9 select 00 back to gpio");
    // R10 unmapped
    reg_write(8'h05, 8'h0F);
    reg_write(8'h01, 8'h0C);
    reg_write(8'h07, 8'hFF);
    reg_write(8'h02, 8'hFF);
    rd_chk(8'h05, 8'h0F, "R10 dir untouched");
    rd_chk(8'h01, 8'h5C, "R10 latch untouched");
    pad_chk(8'h0C, 8'h0F, "R10 pads untouched");
    rd_chk(8'h07, 8'h00, "R10 unmapped read zero");
    step();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule